// File: doc/BRIEF.md
# External Interrupt Sense and Flag Controller

This block watches sixteen external interrupt request pins and turns activity on each pin into a pending flag. Each pin has its own two-bit sense code that picks one of four conditions: low level, falling edge, rising edge, or either edge. Every pin first passes through a two-flop synchronizer. A detector then compares the synchronized level with its value one clock earlier. When a pin's condition is met, the flag at that pin's bit position in a 16-bit status register is set.

Software reads the status register and clears flags by writing zeros. Writing a one leaves that flag as it is. A 16-bit enable mask gates the flags onto a per-pin request vector, and a single combined request line is the OR of that vector. Flags keep latching while their enable bit is off. All three registers sit behind a small register port with a word address, a write strobe and a combinational read path. A synchronous standby input forces the status register to zero for as long as it is high.

There is no streaming data path. Every pin on the block is a plain control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the sense register reads 0x00000000, the status register reads 0x0000, the enable register reads 0x0000, and both `irq_req` and `irq_any` are 0.
- R2: Sense code 00 (low level) sets the flag on every clock in which the synchronized pin is low. A zero written to that flag while the pin is still low leaves it reading 1. A pin held low through reset sets its flag shortly after reset.
- R3: Sense code 01 sets the flag on a high-to-low transition of the synchronized pin. A low-to-high transition does not set it.
- R4: Sense code 10 sets the flag on a low-to-high transition. A high-to-low transition does not set it.
- R5: Sense code 11 sets the flag on a transition in either direction.
- R6: A write to the status register clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. Flags never fall without such a write or standby.
- R7: If a set condition and a zero-write hit the same flag in the same clock, the flag ends at 1.
- R8: `irq_req` equals status AND enable, bit by bit, and `irq_any` is the OR of `irq_req`. Flags latch even when their enable bit is 0.
- R9: While `standby` is high, the status register is forced to 0x0000 on the next clock edge, and this overrides any set condition.
- R10: Register addresses are: 0 = sense (32 bits, pin n uses bits 2n+1:2n, code order B,A); 1 = status (bits 15:0, upper bits read 0); 2 = enable (bits 15:0). Address 3 reads 0 and ignores writes.
- R11: A pin change driven just after a falling clock edge shows in the status register after the third following rising edge. The synchronizer and edge history reset to 1, so a pin held high through reset produces no edge.
- R12: A new sense code takes effect on the next clock. The edge history is not cleared by a mode change, so switching modes with a steady pin sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous clear of the status register |
| irq_pin | input | 16 | Asynchronous external request pins |
| reg_addr | input | 2 | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| irq_req | output | 16 | Per-pin enabled request |
| irq_any | output | 1 | OR of all enabled requests |

## Verification
The hardest case to reach from the ports is a zero-write that lands in exactly the clock in which an edge-mode flag would set. Hitting it takes knowledge of the two synchronizer stages plus the flag register. The stimulus drives a falling edge just after a clock's falling edge and waits two more falling edges. It then holds a zero-write to the status register across the third rising edge and expects the flag to survive. A second run shifts the write one clock later and expects the flag to clear. Together the two runs pin down both the set-wins rule and the exact latency. Level-mode clearing while the pin is low, mode switches with a steady pin, and a pin held low through reset complete the boundary set.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SENSE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd2;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_async,
  output logic [N_PINS-1:0] pin_sync
);
  logic [N_PINS-1:0] stage1;

  // Both stages reset high so an idle-high pin shows no transition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '1;
      pin_sync <= '1;
    end else begin
      stage1   <= pin_async;
      pin_sync <= stage1;
    end
  end
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int N_PINS = 16,
  localparam int SENSE_W = 2 * N_PINS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PINS-1:0]  pin_sync,
  input  logic [SENSE_W-1:0] sense,
  output logic [N_PINS-1:0]  hit
);
  logic [N_PINS-1:0] hist;

  // History is never cleared by a mode change.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '1;
    else        hist <= pin_sync;
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    sense_e mode;
    logic   fall, rise;
    assign mode = sense_e'(sense[2*g +: 2]);
    assign fall = hist[g] & ~pin_sync[g];
    assign rise = ~hist[g] & pin_sync[g];
    always_comb begin
      unique case (mode)
        SENSE_LOW:  hit[g] = ~pin_sync[g];
        SENSE_FALL: hit[g] = fall;
        SENSE_RISE: hit[g] = rise;
        SENSE_BOTH: hit[g] = fall | rise;
        default:    hit[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int N_PINS = 16,
  localparam int SENSE_W = 2 * N_PINS,
  localparam int DATA_W  = SENSE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               standby,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wen,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [N_PINS-1:0]  hit,
  output logic [SENSE_W-1:0] sense,
  output logic [N_PINS-1:0]  flags,
  output logic [N_PINS-1:0]  enable,
  output logic [DATA_W-1:0]  rdata
);
  localparam int PAD_W = DATA_W - N_PINS;

  logic              wr_sense, wr_flag, wr_mask;
  logic [N_PINS-1:0] keep;
  logic [N_PINS-1:0] flags_nx;

  assign wr_sense = wen && (addr == ADDR_SENSE);
  assign wr_flag  = wen && (addr == ADDR_FLAG);
  assign wr_mask  = wen && (addr == ADDR_MASK);

  // Zero bits in a status write clear; one bits keep.
  assign keep = wr_flag ? wdata[N_PINS-1:0] : '1;

  // Priority: standby clear, then set, then software clear.
  always_comb begin
    if (standby) flags_nx = '0;
    else         flags_nx = (flags & keep) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense  <= '0;
      flags  <= '0;
      enable <= '0;
    end else begin
      flags <= flags_nx;
      if (wr_sense) sense  <= wdata[SENSE_W-1:0];
      if (wr_mask)  enable <= wdata[N_PINS-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_SENSE: rdata = sense;
      ADDR_FLAG:  rdata = {{PAD_W{1'b0}}, flags};
      ADDR_MASK:  rdata = {{PAD_W{1'b0}}, enable};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int N_PINS = 16,
  localparam int SENSE_W = 2 * N_PINS,
  localparam int DATA_W  = SENSE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic [N_PINS-1:0] irq_pin,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_PINS-1:0] irq_req,
  output logic              irq_any
);
  logic [N_PINS-1:0]  pin_sync;
  logic [N_PINS-1:0]  hit;
  logic [SENSE_W-1:0] sense;
  logic [N_PINS-1:0]  flags;
  logic [N_PINS-1:0]  enable;

  eirq_sync #(.N_PINS(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(irq_pin), .pin_sync(pin_sync)
  );

  eirq_detect #(.N_PINS(N_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .sense(sense), .hit(hit)
  );

  eirq_regs #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .addr(reg_addr), .wen(reg_wen), .wdata(reg_wdata), .hit(hit),
    .sense(sense), .flags(flags), .enable(enable), .rdata(reg_rdata)
  );

  assign irq_req = flags & enable;
  assign irq_any = |irq_req;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
  import eirq_pkg::*;
#(
  parameter int N_PINS = 16,
  localparam int SENSE_W = 2 * N_PINS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               standby,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wen,
  input logic [SENSE_W-1:0] reg_wdata,
  input logic [N_PINS-1:0]  flags,
  input logic [N_PINS-1:0]  enable,
  input logic [SENSE_W-1:0] sense,
  input logic               irq_any
);
  logic flag_wr;
  assign flag_wr = reg_wen && (reg_addr == ADDR_FLAG);

  p_keep_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !standby) |=>
      ((flags & $past(flags & reg_wdata[N_PINS-1:0])) == $past(flags & reg_wdata[N_PINS-1:0])));

  p_no_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && !flag_wr) |=> (($past(flags) & ~flags) == '0));

  p_standby_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (flags == '0));

  p_sense_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_SENSE) |=> (sense == $past(reg_wdata)));

  p_masked_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq_any);
endmodule

bind ext_irq_ctrl eirq_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby),
  .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
  .flags(flags), .enable(enable), .sense(sense), .irq_any(irq_any)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic [15:0] irq_pin = 16'hFFFF;
  logic [1:0]  reg_addr;
  logic [1:0]  wr_addr = 2'd0;
  logic [1:0]  mon_addr = 2'd0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_req;
  logic        irq_any;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  logic [1:0]  qa[$];
  logic [31:0] qe[$];
  string       qt[$];

  always #2 clk = ~clk;

  assign reg_addr = reg_wen ? wr_addr : mon_addr;

  ext_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .irq_pin(irq_pin),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_any(irq_any)
  );

  task automatic report();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // Monitor: pops expected register reads and compares.
  initial begin
    forever begin
      wait (qa.size() != 0);
      @(negedge clk);
      mon_addr = qa[0];
      #1;
      checks++;
      if (reg_rdata !== qe[0]) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", qt[0], qa[0], reg_rdata, qe[0]);
      end
      void'(qa.pop_front());
      void'(qe.pop_front());
      void'(qt.pop_front());
    end
  end

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    qa.push_back(a);
    qe.push_back(e);
    qt.push_back(tag);
    wait (qa.size() == 0);
  endtask

  task automatic check_out(input logic [16:0] act, input logic [16:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    irq_pin[n] = v;
    settle();
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 / R11: reset values, no false edge from high pins
    expect_reg(2'd0, 32'h0, "R1 sense reset");
    expect_reg(2'd1, 32'h0, "R1 R11 status reset");
    expect_reg(2'd2, 32'h0, "R1 enable reset");
    @(negedge clk);
    check_out({irq_any, irq_req}, 17'h0, "R1 outputs reset");

    wr(2'd2, 32'h0000FFFF);
    expect_reg(2'd2, 32'h0000FFFF, "R10 enable readback");

    // R2 low level
    set_pin(0, 1'b0);
    expect_reg(2'd1, 32'h1, "R2 level sets");
    @(negedge clk);
    check_out({irq_any, irq_req}, {1'b1, 16'h0001}, "R8 request out");
    wr(2'd1, 32'h0);
    expect_reg(2'd1, 32'h1, "R2 clear while low");
    set_pin(0, 1'b1);
    wr(2'd1, 32'h0);
    expect_reg(2'd1, 32'h0, "R2 clear after high");

    // Modes: pin1 fall, pin2 rise, pin3 both
    wr(2'd0, 32'h000000E4);
    expect_reg(2'd0, 32'h000000E4, "R10 sense readback");
    @(negedge clk);
    irq_pin[1] = 1'b0; irq_pin[2] = 1'b0;
    settle();
    expect_reg(2'd1, 32'h2, "R3 fall sets, R4 fall ignored");
    wr(2'd1, 32'hFFFFFFFD);
    expect_reg(2'd1, 32'h0, "R6 zero clears edge flag");
    set_pin(2, 1'b1);
    expect_reg(2'd1, 32'h4, "R4 rise sets");
    set_pin(3, 1'b0);
    expect_reg(2'd1, 32'hC, "R5 fall in both mode");
    wr(2'd1, 32'hFFFFFFFF);
    expect_reg(2'd1, 32'hC, "R6 ones keep");
    wr(2'd1, 32'hFFFFFFF7);
    expect_reg(2'd1, 32'h4, "R6 selective clear");
    set_pin(3, 1'b1);
    expect_reg(2'd1, 32'hC, "R5 rise in both mode");
    set_pin(1, 1'b1);
    expect_reg(2'd1, 32'hC, "R3 rise ignored");
    wr(2'd1, 32'h0);
    expect_reg(2'd1, 32'h0, "R6 clear all");

    // R7 / R11: clear in the exact clock of the set
    @(negedge clk);
    irq_pin[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_addr = 2'd1; reg_wdata = 32'h0; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
    expect_reg(2'd1, 32'h2, "R7 set beats clear");
    set_pin(1, 1'b1);
    wr(2'd1, 32'h0);
    // one clock later the clear wins
    @(negedge clk);
    irq_pin[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    wr_addr = 2'd1; reg_wdata = 32'h0; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
    expect_reg(2'd1, 32'h0, "R11 flag latency three edges");

    // R8 masking
    set_pin(1, 1'b1);
    wr(2'd2, 32'h00000001);
    set_pin(1, 1'b0);
    expect_reg(2'd1, 32'h2, "R8 latches while disabled");
    @(negedge clk);
    check_out({irq_any, irq_req}, 17'h0, "R8 masked");
    wr(2'd2, 32'h00000002);
    @(negedge clk);
    check_out({irq_any, irq_req}, {1'b1, 16'h0002}, "R8 unmasked");
    set_pin(1, 1'b1);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0000FFFF);

    // R12 mode change keeps history
    set_pin(5, 1'b0);
    expect_reg(2'd1, 32'h20, "R2 pin5 level");
    set_pin(5, 1'b1);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h000004E4);
    settle();
    expect_reg(2'd1, 32'h0, "R12 no flag on mode switch");
    set_pin(5, 1'b0);
    expect_reg(2'd1, 32'h20, "R12 new mode active");

    // R9 standby
    @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    expect_reg(2'd1, 32'h0, "R9 standby clears");

    // R10 unused address
    wr(2'd3, 32'hFFFFFFFF);
    expect_reg(2'd3, 32'h0, "R10 addr3 reads zero");
    expect_reg(2'd0, 32'h000004E4, "R10 addr3 write ignored");

    // R2 pin low through reset
    @(negedge clk);
    irq_pin = 16'hFFFE;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_reg(2'd1, 32'h1, "R2 flag after reset");
    @(negedge clk);
    check_out({irq_any, irq_req}, 17'h0, "R1 enable zero after reset");

    report();
  end
endmodule